// File: doc/BRIEF.md
# Low-Power Alarm Timer

This block is a 32-bit timer peripheral on a simple register bus. It holds a free-running counter with a prescaler, one compare alarm, one periodic event taken from a chosen counter bit, and overflow detection. Each event sets a status bit. Software clears status bits through a clear register, and a mask decides which status bits drive the interrupt line. The alarm can also drive a wake line through its own enable, whatever the interrupt mask says.

The counter is advanced by a slow clock source chosen from several asynchronous source inputs. Each source is synchronized into the bus clock and edge-detected. Every rising edge of the selected source, while the source enable is on, is one counter-clock tick. Writes to the counter-side registers are handed over on counter-clock ticks, and a busy status bit stays up until the handover is complete. Writes to the clock-control register go through their own short handover with a separate busy bit. The source selection can only be changed while the source enable is off, so software turns the source off, selects the new one, and turns it on again.

Bus addresses are byte offsets: control 0x00, counter 0x04, status 0x08, status clear 0x0C, mask set 0x10, mask clear 0x14, mask 0x18, wake enable 0x1C, alarm0 0x20, alarm1 0x24, periodic0 0x30, periodic1 0x34, clock control 0x40. Event bits sit at the same positions in the status, clear, mask-set, mask-clear and mask registers: overflow at bit 0, alarm0 at bit 8, periodic0 at bit 16.

Top module: `lp_alarm_timer`

## Requirements
- R1: After reset, every register reads 0, the status word reads 0, and both irq and wake are 0.
- R2: A write to control, counter, alarm0, alarm1, periodic0, periodic1 or wake enable takes effect on the first counter-clock tick after the write. Status bit 24 reads 1 from the cycle after the write until the third such tick. A write to any of these registers while bit 24 is 1 is dropped.
- R3: Clock control holds the source enable at bit 0 and the source number at bits 10:8. A write raises status bit 28 for a few bus cycles and then takes effect. A write made while bit 28 is 1 is dropped. The source number is updated only if the enable was 0 when the write took effect; otherwise the old number is kept and only the enable bit is written.
- R4: With control bit 0 set, the counter advances once every P+1 counter-clock ticks, where P is control bits 23:16. The tick that applies a control write restarts the prescaler and does not count. With control bit 0 clear, the counter holds.
- R5: A counter write loads the written value on its applying tick, and a counter read returns the current count.
- R6: Status bit 0 is set when the counter steps from 0xFFFFFFFF to 0.
- R7: Status bit 8 is set when the counter steps to the value held in alarm0.
- R8: Status bit 16 is set when the counter bit chosen by periodic0 bits 4:0 goes from 0 to 1 on a step.
- R9: Writing 1 to a bit of the status-clear register clears that status bit, and writing 0 leaves it unchanged. An event in the same cycle wins over the clear.
- R10: Writing 1s to the mask-set or mask-clear register sets or clears the matching mask bits. Bits written as 0 have no effect.
- R11: irq is 1 exactly when some status bit and its mask bit are both 1.
- R12: wake is 1 exactly when status bit 8 and wake-enable bit 8 are both 1, independent of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | 5 | Asynchronous counter clock sources, indexed by source number |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request from alarm0 |

## Verification
The bench drives counter-clock ticks one source edge at a time, so it knows exactly how many ticks each handover uses and which count each one leaves. It preloads the counter just below wrap-around to separate the overflow step from ordinary steps. It sets an alarm a few steps ahead and a periodic bit that rises at a known count, and checks that the status stays 0 on the step before each event and is set on the step itself. A prescaler of 2 shows the counter holding for two ticks and stepping on the third. Repeated writes during busy, source changes tried while enabled, and ticks on an unselected source show the dropping and gating rules.

// File: rtl/lat_pkg.sv
// Shared constants for the low-power alarm timer.
// Assumes a 32-bit data bus and byte addressing of 32-bit registers.
package lat_pkg;
    localparam int DW  = 32;
    localparam int AW  = 8;
    localparam int NEV = 3;

    // register byte offsets
    localparam logic [AW-1:0] OFF_CTRL = 8'h00;
    localparam logic [AW-1:0] OFF_CNT  = 8'h04;
    localparam logic [AW-1:0] OFF_STAT = 8'h08;
    localparam logic [AW-1:0] OFF_SCLR = 8'h0C;
    localparam logic [AW-1:0] OFF_MSET = 8'h10;
    localparam logic [AW-1:0] OFF_MCLR = 8'h14;
    localparam logic [AW-1:0] OFF_MASK = 8'h18;
    localparam logic [AW-1:0] OFF_WAKE = 8'h1C;
    localparam logic [AW-1:0] OFF_AL0  = 8'h20;
    localparam logic [AW-1:0] OFF_AL1  = 8'h24;
    localparam logic [AW-1:0] OFF_PER0 = 8'h30;
    localparam logic [AW-1:0] OFF_PER1 = 8'h34;
    localparam logic [AW-1:0] OFF_CLK  = 8'h40;

    // bit positions
    localparam int EV_OVF   = 0;
    localparam int EV_AL0   = 8;
    localparam int EV_PER0  = 16;
    localparam int BUSY_BIT = 24;
    localparam int CBSY_BIT = 28;
    localparam int PSC_LSB  = 16;
    localparam int SRC_LSB  = 8;

    // internal event index: 0 overflow, 1 alarm0, 2 periodic0
    typedef enum logic [2:0] {
        SY_CTRL, SY_CNT, SY_AL0, SY_AL1, SY_PER0, SY_PER1, SY_WAKE
    } sync_reg_e;

    // spread a compact event vector onto register bit positions
    function automatic logic [DW-1:0] ev_to_word(logic [NEV-1:0] e);
        logic [DW-1:0] w;
        w = '0;
        w[EV_OVF]  = e[0];
        w[EV_AL0]  = e[1];
        w[EV_PER0] = e[2];
        return w;
    endfunction

    // gather register bit positions into a compact event vector
    function automatic logic [NEV-1:0] word_to_ev(logic [DW-1:0] w);
        return {w[EV_PER0], w[EV_AL0], w[EV_OVF]};
    endfunction
endpackage

// File: rtl/lat_tick_gen.sv
// Counter clock source selection and tick generation.
// Synchronizes every source input into the bus clock, selects one, and
// emits a one-cycle tick on each rising edge while the source is enabled.
// Holds the clock-control register behind its own write handover.
// Assumes the sources are much slower than the bus clock.
module lat_tick_gen #(
    parameter int NSRC     = 5,
    parameter int CLK_SYNC = 4,
    localparam int SRCW    = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CSW     = $clog2(CLK_SYNC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic            cw_valid,
    input  logic            cw_en,
    input  logic [SRCW-1:0] cw_src,
    output logic            clk_busy,
    output logic            src_en,
    output logic [SRCW-1:0] src_num,
    output logic            tick
);
    logic [NSRC-1:0] meta_q, sync_q;
    logic [CSW-1:0]  cs_cnt_q;
    logic            pend_en_q;
    logic [SRCW-1:0] pend_src_q;
    logic            en_q;
    logic [SRCW-1:0] src_q;
    logic            sel_sig, prev_q;

    // two-flop synchronizer per source
    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= src_clk[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign clk_busy = (cs_cnt_q != '0);

    // clock-control handover: capture, count down, then apply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_cnt_q   <= '0;
            pend_en_q  <= 1'b0;
            pend_src_q <= '0;
            en_q       <= 1'b0;
            src_q      <= '0;
        end else if (cw_valid && !clk_busy) begin
            cs_cnt_q   <= CSW'(CLK_SYNC);
            pend_en_q  <= cw_en;
            pend_src_q <= cw_src;
        end else if (clk_busy) begin
            cs_cnt_q <= cs_cnt_q - 1'b1;
            if (cs_cnt_q == CSW'(1)) begin
                en_q <= pend_en_q;
                if (!en_q) src_q <= pend_src_q;
            end
        end
    end

    // select the synchronized source, unknown numbers select nothing
    always_comb begin
        sel_sig = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (src_q == SRCW'(i)) sel_sig = sync_q[i];
    end

    // edge detector history
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_sig;
    end

    assign tick    = en_q & sel_sig & ~prev_q;
    assign src_en  = en_q;
    assign src_num = src_q;

    // R3: the source number never moves while the source is enabled
    assert_src_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(src_q));
    // R3: an accepted write raises clock busy
    assert_clk_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !clk_busy) |=> clk_busy);
endmodule

// File: rtl/lat_count_core.sv
// Counter-domain logic: write handover, prescaler, counter, alarm,
// periodic and overflow events, and the counter-side register copies.
// All state moves only on counter-clock ticks, except the capture of a
// pending write. Assumes tick is a one-cycle pulse.
module lat_count_core
    import lat_pkg::*;
#(
    parameter int PSC_W      = 8,
    parameter int BUSY_TICKS = 3,
    localparam int BCW       = $clog2(BUSY_TICKS + 1),
    localparam int PSELW     = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           wr_valid,
    input  sync_reg_e      wr_reg,
    input  logic [DW-1:0]  wr_data,
    output logic           busy,
    output logic [DW-1:0]  count,
    output logic           run,
    output logic [PSC_W-1:0] psc,
    output logic [DW-1:0]  alarm0,
    output logic [DW-1:0]  alarm1,
    output logic [DW-1:0]  per0,
    output logic [DW-1:0]  per1,
    output logic           wake_en,
    output logic [NEV-1:0] evt
);
    logic [BCW-1:0]   bcnt_q;
    sync_reg_e        pend_reg_q;
    logic [DW-1:0]    pend_data_q;
    logic             apply, ld_ctrl, ld_cnt, cnt_en, step;
    logic [PSC_W-1:0] pcnt_q;
    logic [DW-1:0]    cnt_q, cnt_nxt;
    logic [PSELW-1:0] pbit;

    assign busy = (bcnt_q != '0);

    // capture a write and count the handover ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q      <= '0;
            pend_reg_q  <= SY_CTRL;
            pend_data_q <= '0;
        end else if (wr_valid && !busy) begin
            bcnt_q      <= BCW'(BUSY_TICKS);
            pend_reg_q  <= wr_reg;
            pend_data_q <= wr_data;
        end else if (tick && busy) begin
            bcnt_q <= bcnt_q - 1'b1;
        end
    end

    assign apply   = tick && (bcnt_q == BCW'(BUSY_TICKS));
    assign ld_ctrl = apply && (pend_reg_q == SY_CTRL);
    assign ld_cnt  = apply && (pend_reg_q == SY_CNT);
    assign cnt_en  = tick && run && !ld_ctrl && !ld_cnt;
    assign step    = cnt_en && (pcnt_q == psc);
    assign cnt_nxt = cnt_q + 1'b1;
    assign pbit    = per0[PSELW-1:0];

    // apply the pending write to its counter-side copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            psc     <= '0;
            alarm0  <= '0;
            alarm1  <= '0;
            per0    <= '0;
            per1    <= '0;
            wake_en <= 1'b0;
        end else if (apply) begin
            case (pend_reg_q)
                SY_CTRL: begin
                    run <= pend_data_q[0];
                    psc <= pend_data_q[PSC_LSB +: PSC_W];
                end
                SY_AL0:  alarm0  <= pend_data_q;
                SY_AL1:  alarm1  <= pend_data_q;
                SY_PER0: per0    <= pend_data_q;
                SY_PER1: per1    <= pend_data_q;
                SY_WAKE: wake_en <= pend_data_q[EV_AL0];
                default: ;
            endcase
        end
    end

    // prescaler phase
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (ld_ctrl) pcnt_q <= '0;
        else if (cnt_en) pcnt_q <= step ? '0 : pcnt_q + 1'b1;
    end

    // the counter itself
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ld_cnt) cnt_q <= pend_data_q;
        else if (step)   cnt_q <= cnt_nxt;
    end

    assign count  = cnt_q;
    assign evt[0] = step && (cnt_q == '1);
    assign evt[1] = step && (cnt_nxt == alarm0);
    assign evt[2] = step && !cnt_q[pbit] && cnt_nxt[pbit];

    // R4: the counter moves only on a counter-clock tick
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R6: an overflow event leaves the counter at zero
    assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> (cnt_q == '0));
    // R7: an alarm event leaves the counter equal to alarm0
    assert_alarm_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |=> (cnt_q == alarm0));
    // R2: an accepted write raises busy
    assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !busy) |=> busy);
endmodule

// File: rtl/lat_regfile.sv
// Bus-side register file: address decode, status with write-one-clear,
// mask set and clear views, read mux, interrupt and wake outputs.
// Reads return data one cycle after the strobe. Assumes one access per
// strobe cycle.
module lat_regfile
    import lat_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int SRCW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_rvalid,
    output logic             sw_valid,
    output sync_reg_e        sw_reg,
    output logic             cw_valid,
    input  logic             busy,
    input  logic             clk_busy,
    input  logic             src_en,
    input  logic [SRCW-1:0]  src_num,
    input  logic [DW-1:0]    count,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    input  logic [DW-1:0]    alarm0,
    input  logic [DW-1:0]    alarm1,
    input  logic [DW-1:0]    per0,
    input  logic [DW-1:0]    per1,
    input  logic             wake_en,
    input  logic [NEV-1:0]   evt,
    output logic             irq,
    output logic             wake
);
    logic           wr;
    logic [NEV-1:0] st_q, im_q, wbits;
    logic [DW-1:0]  rd_word;
    logic [DW-1:0]  ctrl_word, clk_word;

    assign wr    = bus_sel && bus_we;
    assign wbits = word_to_ev(bus_wdata);

    // decode writes to the counter-side registers
    always_comb begin
        sw_valid = wr;
        sw_reg   = SY_CTRL;
        case (bus_addr)
            OFF_CTRL: sw_reg = SY_CTRL;
            OFF_CNT:  sw_reg = SY_CNT;
            OFF_AL0:  sw_reg = SY_AL0;
            OFF_AL1:  sw_reg = SY_AL1;
            OFF_PER0: sw_reg = SY_PER0;
            OFF_PER1: sw_reg = SY_PER1;
            OFF_WAKE: sw_reg = SY_WAKE;
            default:  sw_valid = 1'b0;
        endcase
    end

    assign cw_valid = wr && (bus_addr == OFF_CLK);

    // status: events set, write-one clears, events win
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else if (wr && bus_addr == OFF_SCLR) st_q <= evt | (st_q & ~wbits);
        else st_q <= st_q | evt;
    end

    // mask: set view and clear view
    always_ff @(posedge clk) begin
        if (!rst_n) im_q <= '0;
        else if (wr && bus_addr == OFF_MSET) im_q <= im_q | wbits;
        else if (wr && bus_addr == OFF_MCLR) im_q <= im_q & ~wbits;
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[0] = run;
        ctrl_word[PSC_LSB +: PSC_W] = psc;
        clk_word = '0;
        clk_word[0] = src_en;
        clk_word[SRC_LSB +: SRCW] = src_num;
    end

    // read mux
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFF_CTRL: rd_word = ctrl_word;
            OFF_CNT:  rd_word = count;
            OFF_STAT: begin
                rd_word = ev_to_word(st_q);
                rd_word[BUSY_BIT] = busy;
                rd_word[CBSY_BIT] = clk_busy;
            end
            OFF_MASK: rd_word = ev_to_word(im_q);
            OFF_WAKE: rd_word[EV_AL0] = wake_en;
            OFF_AL0:  rd_word = alarm0;
            OFF_AL1:  rd_word = alarm1;
            OFF_PER0: rd_word = per0;
            OFF_PER1: rd_word = per1;
            OFF_CLK:  rd_word = clk_word;
            default:  rd_word = '0;
        endcase
    end

    // registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_sel && !bus_we;
            bus_rdata  <= (bus_sel && !bus_we) ? rd_word : '0;
        end
    end

    assign irq  = |(st_q & im_q);
    assign wake = st_q[1] & wake_en;

    // R9: clearing the alarm bit without a new alarm event leaves it 0
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_SCLR && bus_wdata[EV_AL0] && !evt[1]) |=> !st_q[1]);
    // R10: every bit written as 1 to the set view ends up set
    assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_MSET) |=> ((im_q & $past(wbits)) == $past(wbits)));
    // R9: a status bit set by an event stays set until a clear write
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[0] && !(wr && bus_addr == OFF_SCLR)) |=> st_q[0]);
endmodule

// File: rtl/lp_alarm_timer.sv
// Top level of the low-power alarm timer: clock source selection, the
// counter-side core and the bus register file.
// Assumes src_clk inputs are asynchronous and slow relative to clk.
module lp_alarm_timer
    import lat_pkg::*;
#(
    parameter int NSRC       = 5,
    parameter int CLK_SYNC   = 4,
    parameter int BUSY_TICKS = 3,
    parameter int PSC_W      = 8,
    localparam int SRCW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    output logic            irq,
    output logic            wake
);
    logic             tick, clk_busy, src_en, busy, cw_valid, sw_valid;
    logic [SRCW-1:0]  src_num;
    sync_reg_e        sw_reg;
    logic [DW-1:0]    count, alarm0, alarm1, per0, per1;
    logic             run, wake_en;
    logic [PSC_W-1:0] psc;
    logic [NEV-1:0]   evt;

    lat_tick_gen #(.NSRC(NSRC), .CLK_SYNC(CLK_SYNC)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
        .cw_valid(cw_valid), .cw_en(bus_wdata[0]),
        .cw_src(bus_wdata[SRC_LSB +: SRCW]),
        .clk_busy(clk_busy), .src_en(src_en), .src_num(src_num), .tick(tick)
    );

    lat_count_core #(.PSC_W(PSC_W), .BUSY_TICKS(BUSY_TICKS)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_valid(sw_valid), .wr_reg(sw_reg), .wr_data(bus_wdata),
        .busy(busy), .count(count), .run(run), .psc(psc),
        .alarm0(alarm0), .alarm1(alarm1), .per0(per0), .per1(per1),
        .wake_en(wake_en), .evt(evt)
    );

    lat_regfile #(.PSC_W(PSC_W), .SRCW(SRCW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .sw_valid(sw_valid), .sw_reg(sw_reg), .cw_valid(cw_valid),
        .busy(busy), .clk_busy(clk_busy), .src_en(src_en), .src_num(src_num),
        .count(count), .run(run), .psc(psc),
        .alarm0(alarm0), .alarm1(alarm1), .per0(per0), .per1(per1),
        .wake_en(wake_en), .evt(evt), .irq(irq), .wake(wake)
    );
endmodule

// File: tb/test_lp_alarm_timer.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them when read data returns. Pin checks compare directly.
module test_lp_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_clk = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq, wake;
    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    lp_alarm_timer i_lp_alarm_timer (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq(irq), .wake(wake)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        @(negedge clk);
    endtask

    task automatic pin(input logic act, input logic e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, e);
        end
    endtask

    task automatic pulse(input int s, input int n);
        for (int k = 0; k < n; k++) begin
            src_clk[s] = 1'b1;
            repeat (6) @(negedge clk);
            src_clk[s] = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic swr(input logic [7:0] a, input logic [31:0] d, input int s);
        wr(a, d);
        pulse(s, 3);
    endtask

    // monitor: compare returned read data against the queue
    always @(negedge clk) begin
        if (bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read actual %08h", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual %08h expected %08h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h08, 32'h0, "R1 status");
        rd(8'h00, 32'h0, "R1 control");
        rd(8'h04, 32'h0, "R1 counter");
        rd(8'h18, 32'h0, "R1 mask");
        rd(8'h40, 32'h0, "R1 clock");
        pin(irq, 0, "R1 irq");
        pin(wake, 0, "R1 wake");
        // R3 clock select then enable
        wr(8'h40, 32'h100);
        rd(8'h08, 32'h1000_0000, "R3 clock busy");
        repeat (8) @(negedge clk);
        rd(8'h40, 32'h100, "R3 select src1");
        wr(8'h40, 32'h101);
        repeat (8) @(negedge clk);
        rd(8'h40, 32'h101, "R3 enable");
        // R2 / R5 counter load with counter stopped
        wr(8'h04, 32'hFFFF_FFFD);
        rd(8'h08, 32'h0100_0000, "R2 busy");
        pulse(1, 3);
        rd(8'h08, 32'h0, "R2 busy cleared");
        rd(8'h04, 32'hFFFF_FFFD, "R5 counter load");
        swr(8'h30, 32'd31, 1);
        // R2 dropped write
        wr(8'h20, 32'h55);
        wr(8'h20, 32'h66);
        pulse(1, 3);
        rd(8'h20, 32'h55, "R2 write during busy dropped");
        // R4 / R6 enable, step to wrap
        swr(8'h00, 32'h1, 1);
        rd(8'h04, 32'hFFFF_FFFF, "R4 two steps after enable");
        rd(8'h08, 32'h0, "R6 no overflow before wrap");
        pulse(1, 1);
        rd(8'h08, 32'h1, "R6 overflow on wrap");
        rd(8'h04, 32'h0, "R6 counter zero");
        pin(irq, 0, "R11 masked");
        wr(8'h10, 32'h1);
        pin(irq, 1, "R11 unmasked");
        wr(8'h10, 32'h0);
        rd(8'h18, 32'h1, "R10 zero bits no effect");
        wr(8'h0C, 32'h1);
        rd(8'h08, 32'h0, "R9 clear");
        pin(irq, 0, "R11 after clear");
        // R7 alarm
        swr(8'h20, 32'd5, 1);
        rd(8'h08, 32'h0, "R7 no alarm at 3");
        pulse(1, 1);
        rd(8'h08, 32'h0, "R7 no alarm at 4");
        pulse(1, 1);
        rd(8'h08, 32'h100, "R7 alarm at 5");
        pin(wake, 0, "R12 wake disabled");
        pin(irq, 0, "R11 alarm masked");
        wr(8'h10, 32'h100);
        pin(irq, 1, "R10 set alarm mask");
        wr(8'h14, 32'h100);
        pin(irq, 0, "R10 clear alarm mask");
        rd(8'h18, 32'h1, "R10 mask after clear");
        swr(8'h1C, 32'h100, 1);
        pin(wake, 1, "R12 wake enabled");
        rd(8'h1C, 32'h100, "R12 wake enable readback");
        wr(8'h0C, 32'h100);
        pin(wake, 0, "R12 wake after clear");
        rd(8'h08, 32'h0, "R9 alarm cleared");
        // R8 periodic on bit 2
        swr(8'h30, 32'd2, 1);
        rd(8'h08, 32'h0, "R8 no event at 11");
        pulse(1, 1);
        rd(8'h08, 32'h1_0000, "R8 event at 12");
        rd(8'h04, 32'd12, "R8 counter");
        wr(8'h0C, 32'h1_0000);
        // R4 prescaler 2
        swr(8'h00, 32'h0002_0001, 1);
        rd(8'h04, 32'd12, "R4 prescale holds");
        pulse(1, 1);
        rd(8'h04, 32'd13, "R4 prescale third tick");
        pulse(1, 2);
        rd(8'h04, 32'd13, "R4 prescale holds again");
        pulse(1, 1);
        rd(8'h04, 32'd14, "R4 prescale step");
        rd(8'h00, 32'h0002_0001, "R4 control readback");
        swr(8'h00, 32'h0, 1);
        pulse(1, 2);
        rd(8'h04, 32'd14, "R4 disabled holds");
        // R3 source change rules
        wr(8'h40, 32'h201);
        repeat (8) @(negedge clk);
        rd(8'h40, 32'h101, "R3 source kept while enabled");
        wr(8'h40, 32'h200);
        repeat (8) @(negedge clk);
        rd(8'h40, 32'h100, "R3 disable keeps source");
        wr(8'h40, 32'h200);
        wr(8'h40, 32'h201);
        repeat (8) @(negedge clk);
        rd(8'h40, 32'h200, "R3 write during clock busy dropped");
        wr(8'h40, 32'h201);
        repeat (8) @(negedge clk);
        rd(8'h40, 32'h201, "R3 src2 enabled");
        wr(8'h04, 32'd7);
        pulse(1, 3);
        rd(8'h08, 32'h0100_0000, "R3 unselected source no tick");
        rd(8'h04, 32'd14, "R3 counter unchanged");
        pulse(2, 3);
        rd(8'h08, 32'h0, "R2 handover on src2");
        rd(8'h04, 32'd7, "R5 load via src2");
        swr(8'h24, 32'hA5A5, 2);
        rd(8'h24, 32'hA5A5, "R2 alarm1 readback");
        swr(8'h34, 32'h5A, 2);
        rd(8'h34, 32'h5A, "R2 periodic1 readback");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d reads expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule